// File: doc/BRIEF.md
# Cascaded Level Interrupt Hub

This block collects sixteen level-type interrupt request lines and folds them into a single request line. That line feeds one input of a parent interrupt controller. Each source passes through two separate gates, each one bit wide per source. The enable gate decides whether an active source latches into a pending bit. The mask gate decides whether a pending bit drives the combined output. Software identifies and services the sources by reading the pending register.

A small synchronous register bus reaches all of the state. Neither gate is ever written directly. Each gate has one address where a 1 bit sets the gate bit and another address where a 1 bit clears it. Zero bits leave the state as it is. The pending register is acknowledged by writing ones to it. Read data is registered. The combined output is also registered, so it follows the pending and mask state one clock later.

Top module: `cirq_hub`

## Requirements
- R1: While `rst` is high, and after it falls, every enable, mask and pending bit is zero, `irq_out` is low and `bus_rdata` is zero.
- R2: Byte addresses use a stride of 4. Offset 0x00 is pending status, 0x04 is enable-set, 0x08 is enable-clear, 0x0C is mask-set and 0x10 is mask-clear. Any other offset is undefined.
- R3: A write to enable-set sets the enable bits where `bus_wdata` is 1. A write to enable-clear clears them. Bits written as 0 keep their value, and the enable state changes at no other time.
- R4: A write to mask-set or mask-clear changes the mask bits in the same way, independently of the enable state.
- R5: A pending bit becomes 1 at the clock edge where its source input is high and its enable bit is 1. It stays 1 after the source falls, until it is acknowledged.
- R6: A write to the status address clears each pending bit written as 1. Bits written as 0 keep their value.
- R7: If an acknowledge and a new latch condition meet on the same pending bit at the same edge, the bit stays 1.
- R8: `irq_out` is the OR of the pending bits whose mask bit is 1, as they stood one clock earlier.
- R9: When `bus_rd` is high at an edge, `bus_rdata` shows the state before that edge from the next clock on. Status gives pending, either enable address gives the enable vector, either mask address gives the mask vector, and undefined offsets give zero. With no read, `bus_rdata` is zero.
- R10: Writing 0xFFFF to enable-clear, mask-clear and status leaves every source disabled, masked and acknowledged. `irq_out` then stays low even while all sources are held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (5) | Byte address of the register |
| bus_wdata | input | NSRC (16) | Write data |
| bus_rdata | output | NSRC (16) | Registered read data |
| irq_src | input | NSRC (16) | Level interrupt source lines |
| irq_out | output | 1 | Combined interrupt request to the parent |

## Verification
The bench aims first at the race between an acknowledge and a source that is still high. A design where the acknowledge wins would drop a live request for one cycle and lose the level. It also checks that a source whose enable bit is off never latches. A design that gated only at the output would then report stale pending bits.

The bench checks that zero bits in set, clear and acknowledge writes leave state alone. A design that wrote the register directly would wipe neighbouring bits. It also confirms that both enable addresses, and both mask addresses, read back the same vector, and that unused offsets read zero. Finally it runs the full shutdown sequence with all sources held high and confirms that the output stays quiet.

// File: rtl/cirq_pkg.sv
package cirq_pkg;

  // Register offsets (byte addresses, 4-byte stride)
  localparam int unsigned OFS_STAT  = 0;
  localparam int unsigned OFS_ENSET = 4;
  localparam int unsigned OFS_ENCLR = 8;
  localparam int unsigned OFS_MKSET = 12;
  localparam int unsigned OFS_MKCLR = 16;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STAT,
    SEL_ENSET,
    SEL_ENCLR,
    SEL_MKSET,
    SEL_MKCLR
  } sel_e;

  function automatic sel_e decode_sel(input int unsigned a);
    case (a)
      OFS_STAT:  decode_sel = SEL_STAT;
      OFS_ENSET: decode_sel = SEL_ENSET;
      OFS_ENCLR: decode_sel = SEL_ENCLR;
      OFS_MKSET: decode_sel = SEL_MKSET;
      OFS_MKCLR: decode_sel = SEL_MKCLR;
      default:   decode_sel = SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/cirq_gate.sv
// One set/clear gate vector: ones set or clear bits, zeros leave them.
module cirq_gate #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] bits,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (set_stb) q <= q | bits;
    else if (clr_stb) q <= q & ~bits;
  end

  // R3 R4
  gate_set_chk: assert property (@(posedge clk) disable iff (rst)
    set_stb |=> ((q & $past(bits)) == $past(bits)));

  // R3 R4
  gate_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_stb && !set_stb) |=> ((q & $past(bits)) == '0));

  // R3 R4
  gate_zero_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (set_stb || clr_stb) |=> ((q & ~$past(bits)) == ($past(q) & ~$past(bits))));

  // R3 R4
  gate_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!set_stb && !clr_stb) |=> $stable(q));

endmodule

// File: rtl/cirq_pending.sv
// Pending status: latched by enabled sources, cleared by write-one acknowledge.
module cirq_pending #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src,
  input  logic [W-1:0] en,
  input  logic         ack_stb,
  input  logic [W-1:0] ack_bits,
  output logic [W-1:0] st
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                         st[g] <= 1'b0;
      else if (src[g] && en[g])        st[g] <= 1'b1;
      else if (ack_stb && ack_bits[g]) st[g] <= 1'b0;
    end
  end

  // R5 R7
  pend_latch_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((st & $past(src & en)) == $past(src & en)));

  // R6
  pend_ack_chk: assert property (@(posedge clk) disable iff (rst)
    ack_stb |=> ((st & $past(ack_bits & ~(src & en))) == '0));

  // R5
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ack_stb |=> ((st & $past(st)) == $past(st)));

endmodule

// File: rtl/cirq_rdmux.sv
// Registered read-back selection.
module cirq_rdmux
  import cirq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd,
  input  sel_e         sel,
  input  logic [W-1:0] st,
  input  logic [W-1:0] en,
  input  logic [W-1:0] mk,
  output logic [W-1:0] rdata
);

  logic [W-1:0] pick;

  always_comb begin
    case (sel)
      SEL_STAT:             pick = st;
      SEL_ENSET, SEL_ENCLR: pick = en;
      SEL_MKSET, SEL_MKCLR: pick = mk;
      default:              pick = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= pick;
    else         rdata <= '0;
  end

  // R9
  rd_undef_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && sel == SEL_NONE) |=> (rdata == '0));

  // R9
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd |=> (rdata == '0));

endmodule

// File: rtl/cirq_hub.sv
module cirq_hub
  import cirq_pkg::*;
#(
  parameter int NSRC   = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NSRC-1:0]   bus_wdata,
  output logic [NSRC-1:0]   bus_rdata,
  input  logic [NSRC-1:0]   irq_src,
  output logic              irq_out
);

  sel_e            sel;
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] mk_q;
  logic [NSRC-1:0] st_q;

  assign sel = decode_sel(int'(bus_addr));

  cirq_gate #(.W(NSRC)) u_en (
    .clk     (clk),
    .rst     (rst),
    .set_stb (bus_wr && sel == SEL_ENSET),
    .clr_stb (bus_wr && sel == SEL_ENCLR),
    .bits    (bus_wdata),
    .q       (en_q)
  );

  cirq_gate #(.W(NSRC)) u_mk (
    .clk     (clk),
    .rst     (rst),
    .set_stb (bus_wr && sel == SEL_MKSET),
    .clr_stb (bus_wr && sel == SEL_MKCLR),
    .bits    (bus_wdata),
    .q       (mk_q)
  );

  cirq_pending #(.W(NSRC)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .src      (irq_src),
    .en       (en_q),
    .ack_stb  (bus_wr && sel == SEL_STAT),
    .ack_bits (bus_wdata),
    .st       (st_q)
  );

  cirq_rdmux #(.W(NSRC)) u_rd (
    .clk   (clk),
    .rst   (rst),
    .rd    (bus_rd),
    .sel   (sel),
    .st    (st_q),
    .en    (en_q),
    .mk    (mk_q),
    .rdata (bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= |(st_q & mk_q);
  end

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_out == $past(|(st_q & mk_q))));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!irq_out && bus_rdata == '0));

endmodule

// File: tb/cirq_hub_test.sv
module cirq_hub_test;

  localparam int NSRC   = 16;
  localparam int ADDR_W = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [NSRC-1:0]   bus_wdata = '0;
  logic [NSRC-1:0]   bus_rdata;
  logic [NSRC-1:0]   irq_src = '0;
  logic              irq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cirq_hub #(.NSRC(NSRC), .ADDR_W(ADDR_W)) uut (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_src   (irq_src),
    .irq_out   (irq_out)
  );

  // Behavioural reference, built from the requirements
  logic [15:0] m_en = '0, m_mk = '0, m_st = '0, m_rd = '0;
  logic        m_irq = 1'b0;

  always @(posedge clk) begin
    logic [15:0] n_en, n_mk, n_st, n_rd;
    logic        n_irq;
    int          a;
    a = int'(bus_addr);
    if (rst) begin
      n_en = '0; n_mk = '0; n_st = '0; n_rd = '0; n_irq = 1'b0;
    end else begin
      n_en = m_en; n_mk = m_mk; n_st = m_st;
      if (bus_wr && a == 4)  n_en = m_en | bus_wdata;
      if (bus_wr && a == 8)  n_en = m_en & ~bus_wdata;
      if (bus_wr && a == 12) n_mk = m_mk | bus_wdata;
      if (bus_wr && a == 16) n_mk = m_mk & ~bus_wdata;
      if (bus_wr && a == 0)  n_st = n_st & ~bus_wdata;
      n_st = n_st | (irq_src & m_en);
      n_irq = (m_st & m_mk) != 0;
      n_rd = '0;
      if (bus_rd) begin
        if (a == 0) n_rd = m_st;
        else if (a == 4 || a == 8) n_rd = m_en;
        else if (a == 12 || a == 16) n_rd = m_mk;
      end
    end
    m_en = n_en; m_mk = n_mk; m_st = n_st; m_rd = n_rd; m_irq = n_irq;
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the model on every clock (R8, R9)
  always @(posedge clk) begin
    #1;
    if (!done) begin
      check("R8 irq_out vs model", {15'b0, irq_out}, {15'b0, m_irq});
      check("R9 bus_rdata vs model", bus_rdata, m_rd);
    end
  end

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_chk(input int a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = ADDR_W'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    check(tag, bus_rdata, exp);
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    @(negedge clk);
    @(negedge clk);
    check(tag, {15'b0, irq_out}, {15'b0, exp});
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 irq during reset", {15'b0, irq_out}, 16'h0);
    check("R1 rdata during reset", bus_rdata, 16'h0);
    rst = 1'b0;
    // R1 reset state through the bus
    rd_chk(0,  16'h0, "R1 status after reset");
    rd_chk(4,  16'h0, "R1 enable after reset");
    rd_chk(12, 16'h0, "R1 mask after reset");
    // R3 enable set/clear, R9 both addresses read enable
    wr(4, 16'h00F0);
    wr(4, 16'h0003);
    rd_chk(4, 16'h00F3, "R3 enable set accumulates");
    wr(8, 16'h0010);
    rd_chk(8, 16'h00E3, "R3 enable clear one bit via R9 clear addr");
    wr(8, 16'h0000);
    rd_chk(4, 16'h00E3, "R3 zero clear bits no effect");
    // R4 mask, R2 offsets 0x0C and 0x10
    wr(12, 16'h8003);
    wr(16, 16'h8000);
    rd_chk(16, 16'h0003, "R4 mask set then clear (R2 offsets)");
    rd_chk(4, 16'h00E3, "R4 mask writes leave enable");
    // R5 latch: enabled source bit 0, disabled bit 8
    @(negedge clk); irq_src = 16'h0101;
    @(negedge clk); irq_src = 16'h0000;
    rd_chk(0, 16'h0001, "R5 only enabled source latches");
    irq_chk(1'b1, "R8 masked-in pending drives irq");
    rd_chk(0, 16'h0001, "R5 pending held after source falls");
    // R6 ack with zero bits then one bits
    wr(0, 16'h0000);
    rd_chk(0, 16'h0001, "R6 zero ack bits no effect");
    wr(0, 16'h0001);
    rd_chk(0, 16'h0000, "R6 ack clears pending");
    irq_chk(1'b0, "R8 irq drops after ack");
    // R8 pending with mask off does not drive irq
    @(negedge clk); irq_src = 16'h0020;
    @(negedge clk); irq_src = 16'h0000;
    rd_chk(0, 16'h0020, "R5 bit 5 latched");
    irq_chk(1'b0, "R8 unmasked-off pending keeps irq low");
    wr(0, 16'h0020);
    // R7 ack while source still high
    @(negedge clk); irq_src = 16'h0002;
    wr(0, 16'h0002);
    rd_chk(0, 16'h0002, "R7 set wins over ack");
    irq_chk(1'b1, "R7 irq stays asserted");
    @(negedge clk); irq_src = 16'h0000;
    // R9 undefined offsets
    rd_chk(20, 16'h0000, "R9 undefined offset 0x14");
    rd_chk(28, 16'h0000, "R9 undefined offset 0x1C");
    rd_chk(2,  16'h0000, "R9 unaligned offset 0x02");
    // R10 full shutdown with all sources high
    @(negedge clk); irq_src = 16'hFFFF;
    wr(8,  16'hFFFF);
    wr(16, 16'hFFFF);
    wr(0,  16'hFFFF);
    repeat (4) @(negedge clk);
    rd_chk(0,  16'h0000, "R10 status cleared");
    rd_chk(4,  16'h0000, "R10 enable cleared");
    rd_chk(12, 16'h0000, "R10 mask cleared");
    irq_chk(1'b0, "R10 irq quiet with sources high");
    @(negedge clk); irq_src = 16'h0000;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule